// File: doc/BRIEF.md
# Eight-Channel Block DMA Engine

This block moves bytes between a 24-bit memory bus and a peripheral register window. The memory address is an 8-bit bank plus a 16-bit offset. The peripheral window is a 16-bit address space whose upper byte is always 0x21. Software first programs the per-channel registers. It then writes an enable mask, and every selected channel runs to completion in turn, lowest index first.

While the engine runs, it holds `busy` high; this is the stall applied to the host processor. One clock is one master cycle. The engine charges a fixed, documented number of master cycles for each of the following:

- alignment to an 8-cycle grid at entry and at exit;
- a fixed overhead for the whole operation and for each channel;
- each byte moved.

The running cost is visible on `cost`, so the stall length can be checked cycle by cycle.

Each byte has a 4-cycle read phase on the source side, then a 4-cycle write phase on the destination side. A direction bit sets which side is the source. The peripheral address is formed by adding an offset to the channel's 8-bit destination byte. That offset steps through a short list selected by the channel's pattern mode.

Top module: `blk_dma_engine`

## Requirements
- R1: After reset, `busy`, all four bus strobes and `cost` are 0.
- R2: A `start_we` pulse while idle starts every channel whose `start_mask` bit is set, and the channels run in ascending index order.
  - A master phase counter counts clocks since reset modulo 8; it reads 0 in the first cycle after reset is released.
  - Configuration writes use `cfg_addr[5:3]` as the channel and `cfg_addr[2:0]` as the field:
    - field 0 is control: bit0 direction, bit1 fixed, bits4:2 pattern mode;
    - field 1 is the destination byte;
    - field 2 is the offset low byte and field 3 the offset high byte;
    - field 4 is the bank;
    - field 5 is the count low byte and field 6 the count high bits.
- R3: Call c the phase counter value in the cycle of an accepted start. The engine first waits 8 − c cycles, so it waits 8 cycles when c is 0 and 1 cycle when c is 7.
- R4: After the entry wait, 8 cycles of overhead are charged once. Then each enabled channel is charged 8 cycles before its first byte.
- R5: Each byte takes 4 cycles with the source read strobe held high, then 4 cycles with the destination write strobe held high. At most one strobe is high in any cycle. The written byte is the one read during the read phase.
- R6: The peripheral address is 0x2100 OR (destination + offset), where the 8-bit sum wraps and the offset advances once per byte. The offset lists by mode are:
  - mode 0: 0;
  - modes 1 and 5: 0,1 repeating;
  - modes 2 and 6: 0;
  - modes 3 and 7: 0,0,1,1 repeating;
  - mode 4: 0,1,2,3 repeating.
  - The list restarts at each channel's start.
- R7: With direction 0, data is read from the memory side and written to the peripheral side. With direction 1, data is read from the peripheral side and written to the memory side.
- R8: Unless the fixed bit is set, the 16-bit memory offset advances by 1 after every byte, wrapping within the bank. The bank never changes. The advanced offset is kept in the channel register for the next start.
- R9: The count decrements once per byte, and the channel ends when it reaches 0. A count of 0 means 2^COUNT_W bytes. The decremented count is kept in the channel register.
- R10: After the last channel, or right after the overhead if the mask is 0, the engine waits 8 − (phase mod 8) cycles and then drops `busy`.
- R11: `busy` is high from the cycle after an accepted start through the final wait. A `start_we` while busy is ignored.
- R12: `cost` is 1 in the first busy cycle and rises by 1 each busy cycle. After `busy` falls, it holds the total number of busy cycles until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, one master cycle per period |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Channel register write strobe |
| cfg_addr | input | 6 | Channel (bits 5:3) and field (bits 2:0) |
| cfg_wdata | input | 8 | Channel register write data |
| start_we | input | 1 | Enable-mask write strobe |
| start_mask | input | 8 | Channels to run, one bit each |
| mem_addr | output | 24 | Memory-side address: bank and offset |
| mem_rd | output | 1 | Memory-side read strobe |
| mem_wr | output | 1 | Memory-side write strobe |
| mem_rdata | input | 8 | Memory-side read data |
| per_addr | output | 16 | Peripheral-side address |
| per_rd | output | 1 | Peripheral-side read strobe |
| per_wr | output | 1 | Peripheral-side write strobe |
| per_rdata | input | 8 | Peripheral-side read data |
| wdata | output | 8 | Write data for either side |
| busy | output | 1 | Processor stall, engine active |
| cost | output | 24 | Master cycles charged by the current or last run |

## Verification
The start is sampled at the clock edge that ends its cycle, so the first entry-wait cycle is the next cycle, and every later result follows at an offset fixed by R3 to R10.

For each start, the reference model precomputes the expected contents of every cycle: `busy`, each strobe, each address, the write data and the cost. It compares them at each falling edge, beginning with the cycle after the accepting edge.

A few idle cycles are then compared after `busy` falls. This catches a late release and checks that the cost is held.

A start pulse injected mid-run must leave the precomputed sequence unchanged. A second run without reprogramming exposes the written-back offset and count.

// File: rtl/dma_pkg.sv
package dma_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ALIGN_IN,
    S_OVH,
    S_CH_OVH,
    S_RD,
    S_WR,
    S_ALIGN_OUT
  } seq_state_t;

  // Last index of the offset list for a pattern mode.
  function automatic logic [1:0] pat_last(input logic [2:0] mode);
    unique case (mode)
      3'd0:               pat_last = 2'd0;
      3'd1, 3'd2, 3'd6:   pat_last = 2'd1;
      default:            pat_last = 2'd3;
    endcase
  endfunction

  // Peripheral offset for a mode at list position idx.
  function automatic logic [1:0] pat_off(input logic [2:0] mode, input logic [1:0] idx);
    unique case (mode)
      3'd1, 3'd5: pat_off = {1'b0, idx[0]};
      3'd3, 3'd7: pat_off = {1'b0, idx[1]};
      3'd4:       pat_off = idx;
      default:    pat_off = 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter int NUM_CH  = 8,
  parameter int COUNT_W = 16,
  parameter int CH_W    = 3,
  parameter int CFG_AW  = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [CFG_AW-1:0]  cfg_addr,
  input  logic [7:0]         cfg_wdata,
  input  logic [CH_W-1:0]    sel_ch,
  input  logic               upd_en,
  input  logic [15:0]        upd_off,
  input  logic [COUNT_W-1:0] upd_cnt,
  output logic               ch_dir,
  output logic               ch_fixed,
  output logic [2:0]         ch_mode,
  output logic [7:0]         ch_dest,
  output logic [7:0]         ch_bank,
  output logic [15:0]        ch_off,
  output logic [COUNT_W-1:0] ch_cnt
);

  logic [4:0]         ctrl_a [NUM_CH];
  logic [7:0]         dest_a [NUM_CH];
  logic [7:0]         bank_a [NUM_CH];
  logic [15:0]        off_a  [NUM_CH];
  logic [COUNT_W-1:0] cnt_a  [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic [4:0]         ctrl_r;
    logic [7:0]         dest_r;
    logic [7:0]         bank_r;
    logic [15:0]        off_r;
    logic [COUNT_W-1:0] cnt_r;
    logic               hit;
    logic               upd_hit;

    assign hit     = cfg_we && (cfg_addr[CFG_AW-1:3] == CH_W'(g));
    assign upd_hit = upd_en && (sel_ch == CH_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        ctrl_r <= '0;
        dest_r <= '0;
        bank_r <= '0;
        off_r  <= '0;
        cnt_r  <= '0;
      end else if (upd_hit) begin
        off_r <= upd_off;
        cnt_r <= upd_cnt;
      end else if (hit) begin
        unique case (cfg_addr[2:0])
          3'd0:    ctrl_r <= cfg_wdata[4:0];
          3'd1:    dest_r <= cfg_wdata;
          3'd2:    off_r[7:0]  <= cfg_wdata;
          3'd3:    off_r[15:8] <= cfg_wdata;
          3'd4:    bank_r <= cfg_wdata;
          3'd5:    cnt_r[7:0] <= cfg_wdata;
          3'd6:    cnt_r[COUNT_W-1:8] <= cfg_wdata[COUNT_W-9:0];
          default: ;
        endcase
      end
    end

    assign ctrl_a[g] = ctrl_r;
    assign dest_a[g] = dest_r;
    assign bank_a[g] = bank_r;
    assign off_a[g]  = off_r;
    assign cnt_a[g]  = cnt_r;
  end

  assign ch_dir   = ctrl_a[sel_ch][0];
  assign ch_fixed = ctrl_a[sel_ch][1];
  assign ch_mode  = ctrl_a[sel_ch][4:2];
  assign ch_dest  = dest_a[sel_ch];
  assign ch_bank  = bank_a[sel_ch];
  assign ch_off   = off_a[sel_ch];
  assign ch_cnt   = cnt_a[sel_ch];

endmodule

// File: rtl/dma_phase_timer.sv
module dma_phase_timer #(
  parameter int COST_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              busy,
  input  logic              done,
  output logic [2:0]        phase,
  output logic [COST_W-1:0] cost
);

  always_ff @(posedge clk) begin
    if (rst) phase <= 3'd0;
    else     phase <= phase + 3'd1;
  end

  always_ff @(posedge clk) begin
    if (rst)                cost <= '0;
    else if (accept)        cost <= COST_W'(1);
    else if (busy && !done) cost <= cost + COST_W'(1);
  end

  // R10: busy drops only after a cycle with phase 0
  a_r10_exit_phase: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> phase == 3'd1);

  // R12: cost is held while idle with no start
  a_r12_cost_hold: assert property (@(posedge clk) disable iff (rst)
    (!busy && !accept) |=> $stable(cost));

endmodule

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
  import dma_pkg::*;
#(
  parameter int NUM_CH  = 8,
  parameter int COUNT_W = 16,
  parameter int CH_W    = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_we,
  input  logic [NUM_CH-1:0]  start_mask,
  input  logic [2:0]         phase,
  input  logic               ch_dir,
  input  logic               ch_fixed,
  input  logic [2:0]         ch_mode,
  input  logic [7:0]         ch_dest,
  input  logic [7:0]         ch_bank,
  input  logic [15:0]        ch_off,
  input  logic [COUNT_W-1:0] ch_cnt,
  input  logic [7:0]         mem_rdata,
  input  logic [7:0]         per_rdata,
  output logic               busy,
  output logic               accept,
  output logic               done,
  output logic [CH_W-1:0]    sel_ch,
  output logic               upd_en,
  output logic [15:0]        upd_off,
  output logic [COUNT_W-1:0] upd_cnt,
  output logic [23:0]        mem_addr,
  output logic               mem_rd,
  output logic               mem_wr,
  output logic [15:0]        per_addr,
  output logic               per_rd,
  output logic               per_wr,
  output logic [7:0]         wdata
);

  seq_state_t        state_q;
  logic [NUM_CH-1:0] mask_q;
  logic [NUM_CH-1:0] mask_left;
  logic [CH_W-1:0]   ch_q;
  logic [2:0]        sub_q;
  logic [1:0]        pidx_q;
  logic [7:0]        data_q;
  logic              byte_end;
  logic              last_byte;

  function automatic logic [CH_W-1:0] first_set(input logic [NUM_CH-1:0] m);
    first_set = '0;
    for (int i = NUM_CH - 1; i >= 0; i--)
      if (m[i]) first_set = i[CH_W-1:0];
  endfunction

  assign busy      = (state_q != S_IDLE);
  assign accept    = (state_q == S_IDLE) && start_we;
  assign done      = (state_q == S_ALIGN_OUT) && (phase == 3'd0);
  assign byte_end  = (state_q == S_WR) && (sub_q == 3'd3);
  assign last_byte = (ch_cnt == COUNT_W'(1));
  assign mask_left = mask_q & ~(NUM_CH'(1) << ch_q);
  assign sel_ch    = ch_q;
  assign upd_en    = byte_end;
  assign upd_off   = ch_fixed ? ch_off : ch_off + 16'd1;
  assign upd_cnt   = ch_cnt - COUNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      mask_q  <= '0;
      ch_q    <= '0;
      sub_q   <= '0;
      pidx_q  <= '0;
      data_q  <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: begin
          if (start_we) begin
            mask_q  <= start_mask;
            state_q <= S_ALIGN_IN;
          end
        end
        S_ALIGN_IN: begin
          if (phase == 3'd0) begin
            state_q <= S_OVH;
            sub_q   <= 3'd0;
          end
        end
        S_OVH: begin
          sub_q <= sub_q + 3'd1;
          if (sub_q == 3'd7) begin
            if (mask_q == '0) begin
              state_q <= S_ALIGN_OUT;
            end else begin
              ch_q    <= first_set(mask_q);
              pidx_q  <= 2'd0;
              state_q <= S_CH_OVH;
            end
          end
        end
        S_CH_OVH: begin
          sub_q <= sub_q + 3'd1;
          if (sub_q == 3'd7) state_q <= S_RD;
        end
        S_RD: begin
          sub_q <= sub_q + 3'd1;
          if (sub_q == 3'd3) begin
            data_q  <= ch_dir ? per_rdata : mem_rdata;
            sub_q   <= 3'd0;
            state_q <= S_WR;
          end
        end
        S_WR: begin
          sub_q <= sub_q + 3'd1;
          if (sub_q == 3'd3) begin
            sub_q  <= 3'd0;
            pidx_q <= (pidx_q == pat_last(ch_mode)) ? 2'd0 : pidx_q + 2'd1;
            if (last_byte) begin
              mask_q <= mask_left;
              if (mask_left == '0) begin
                state_q <= S_ALIGN_OUT;
              end else begin
                ch_q    <= first_set(mask_left);
                pidx_q  <= 2'd0;
                state_q <= S_CH_OVH;
              end
            end else begin
              state_q <= S_RD;
            end
          end
        end
        S_ALIGN_OUT: begin
          if (phase == 3'd0) state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign mem_addr = {ch_bank, ch_off};
  assign per_addr = {8'h21, ch_dest + {6'd0, pat_off(ch_mode, pidx_q)}};
  assign mem_rd   = (state_q == S_RD) && !ch_dir;
  assign per_rd   = (state_q == S_RD) &&  ch_dir;
  assign per_wr   = (state_q == S_WR) && !ch_dir;
  assign mem_wr   = (state_q == S_WR) &&  ch_dir;
  assign wdata    = data_q;

  // R3: the overhead starts right after a phase-0 cycle
  a_r3_align_in: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_OVH && $past(state_q) == S_ALIGN_IN) |-> phase == 3'd1);

  // R4: a channel's first read follows 8 cycles of channel overhead
  a_r4_ch_ovh: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_RD && $past(state_q) == S_CH_OVH) |-> $past(state_q, 8) == S_CH_OVH);

  // R5: never more than one strobe
  a_r5_one_strobe: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_rd, mem_wr, per_rd, per_wr}));

  // R5: a read strobe lasts beyond its first cycle
  a_r5_read_hold: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_rd || per_rd) |=> (mem_rd || per_rd));

  // R6: peripheral accesses stay in the 0x21xx window
  a_r6_window: assert property (@(posedge clk) disable iff (rst)
    (per_rd || per_wr) |-> per_addr[15:8] == 8'h21);

endmodule

// File: rtl/blk_dma_engine.sv
module blk_dma_engine #(
  parameter int NUM_CH  = 8,
  parameter int COUNT_W = 16,
  parameter int COST_W  = 24
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cfg_we,
  input  logic [$clog2(NUM_CH)+2:0] cfg_addr,
  input  logic [7:0]                cfg_wdata,
  input  logic                      start_we,
  input  logic [NUM_CH-1:0]         start_mask,
  output logic [23:0]               mem_addr,
  output logic                      mem_rd,
  output logic                      mem_wr,
  input  logic [7:0]                mem_rdata,
  output logic [15:0]               per_addr,
  output logic                      per_rd,
  output logic                      per_wr,
  input  logic [7:0]                per_rdata,
  output logic [7:0]                wdata,
  output logic                      busy,
  output logic [COST_W-1:0]         cost
);

  localparam int CH_W   = $clog2(NUM_CH);
  localparam int CFG_AW = CH_W + 3;

  logic               accept;
  logic               done;
  logic [2:0]         phase;
  logic [CH_W-1:0]    sel_ch;
  logic               upd_en;
  logic [15:0]        upd_off;
  logic [COUNT_W-1:0] upd_cnt;
  logic               ch_dir;
  logic               ch_fixed;
  logic [2:0]         ch_mode;
  logic [7:0]         ch_dest;
  logic [7:0]         ch_bank;
  logic [15:0]        ch_off;
  logic [COUNT_W-1:0] ch_cnt;

  dma_chan_regs #(
    .NUM_CH(NUM_CH), .COUNT_W(COUNT_W), .CH_W(CH_W), .CFG_AW(CFG_AW)
  ) i_regs (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .sel_ch(sel_ch), .upd_en(upd_en), .upd_off(upd_off), .upd_cnt(upd_cnt),
    .ch_dir(ch_dir), .ch_fixed(ch_fixed), .ch_mode(ch_mode),
    .ch_dest(ch_dest), .ch_bank(ch_bank), .ch_off(ch_off), .ch_cnt(ch_cnt)
  );

  dma_phase_timer #(.COST_W(COST_W)) i_timer (
    .clk(clk), .rst(rst),
    .accept(accept), .busy(busy), .done(done),
    .phase(phase), .cost(cost)
  );

  dma_seq_ctrl #(
    .NUM_CH(NUM_CH), .COUNT_W(COUNT_W), .CH_W(CH_W)
  ) i_seq (
    .clk(clk), .rst(rst),
    .start_we(start_we), .start_mask(start_mask), .phase(phase),
    .ch_dir(ch_dir), .ch_fixed(ch_fixed), .ch_mode(ch_mode),
    .ch_dest(ch_dest), .ch_bank(ch_bank), .ch_off(ch_off), .ch_cnt(ch_cnt),
    .mem_rdata(mem_rdata), .per_rdata(per_rdata),
    .busy(busy), .accept(accept), .done(done), .sel_ch(sel_ch),
    .upd_en(upd_en), .upd_off(upd_off), .upd_cnt(upd_cnt),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .per_addr(per_addr), .per_rd(per_rd), .per_wr(per_wr),
    .wdata(wdata)
  );

  // R11: a start during a run does not restart the cost count
  a_r11_busy_ignore: assert property (@(posedge clk) disable iff (rst)
    (busy && start_we) |=> cost != COST_W'(1));

endmodule

// File: tb/test_blk_dma_engine.sv
module test_blk_dma_engine;

  localparam int CLK_PERIOD = 10;
  localparam int NCH   = 8;
  localparam int CW    = 9;
  localparam int COSTW = 24;
  localparam int CMOD  = 2 ** CW;

  typedef struct {
    bit          busy;
    bit          mrd, mwr, prd, pwr;
    logic [23:0] ma;
    logic [15:0] pa;
    logic [7:0]  wd;
    int          cost;
  } rec_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [5:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic start_we = 1'b0;
  logic [NCH-1:0] start_mask = '0;
  logic [23:0] mem_addr;
  logic mem_rd, mem_wr;
  logic [7:0] mem_rdata;
  logic [15:0] per_addr;
  logic per_rd, per_wr;
  logic [7:0] per_rdata;
  logic [7:0] wdata;
  logic busy;
  logic [COSTW-1:0] cost;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit finished = 1'b0;

  logic [7:0]  m_ctrl [NCH];
  logic [7:0]  m_dest [NCH];
  logic [7:0]  m_bank [NCH];
  logic [15:0] m_off  [NCH];
  int          m_cnt  [NCH];
  int          pat_tab [8][4];
  int          pat_len [8];
  rec_t        exp_q [$];

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) if (!rst) cyc <= cyc + 1;

  function automatic logic [7:0] mem_resp(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ {a[19:16], a[23:20]};
  endfunction

  function automatic logic [7:0] per_resp(input logic [15:0] a);
    return a[7:0] + 8'h5A;
  endfunction

  assign mem_rdata = mem_resp(mem_addr);
  assign per_rdata = per_resp(per_addr);

  blk_dma_engine #(.NUM_CH(NCH), .COUNT_W(CW), .COST_W(COSTW)) i_blk_dma_engine (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .start_we(start_we), .start_mask(start_mask),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_rdata(mem_rdata),
    .per_addr(per_addr), .per_rd(per_rd), .per_wr(per_wr), .per_rdata(per_rdata),
    .wdata(wdata), .busy(busy), .cost(cost)
  );

  task automatic chk(input bit ok, input string tag, input string lbl, input int i,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s [%s] cycle %0d: actual %0h expected %0h", tag, lbl, i, act, exp);
    end
  endtask

  task automatic cfg_write(input int ch, input int field, input logic [7:0] val);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_addr  = 6'((ch << 3) | field);
    cfg_wdata = val;
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  task automatic program_ch(input int ch, input logic [7:0] ctrl, input logic [7:0] dest,
                            input logic [7:0] bank, input logic [15:0] off, input int cnt);
    cfg_write(ch, 0, ctrl);
    cfg_write(ch, 1, dest);
    cfg_write(ch, 2, off[7:0]);
    cfg_write(ch, 3, off[15:8]);
    cfg_write(ch, 4, bank);
    cfg_write(ch, 5, 8'(cnt));
    cfg_write(ch, 6, 8'(cnt >> 8));
    m_ctrl[ch] = ctrl;
    m_dest[ch] = dest;
    m_bank[ch] = bank;
    m_off[ch]  = off;
    m_cnt[ch]  = cnt % CMOD;
  endtask

  task automatic add(input bit b, input bit mrd, input bit mwr, input bit prd, input bit pwr,
                     input logic [23:0] ma, input logic [15:0] pa, input logic [7:0] wd);
    rec_t r;
    r.busy = b; r.mrd = mrd; r.mwr = mwr; r.prd = prd; r.pwr = pwr;
    r.ma = ma; r.pa = pa; r.wd = wd;
    r.cost = exp_q.size() + 1;
    exp_q.push_back(r);
  endtask

  // Build the expected cycle list from the requirements (R3 R4 R5 R6 R7 R8 R9 R10).
  task automatic build(input int p, input logic [NCH-1:0] mask);
    exp_q.delete();
    repeat (8 - (p % 8)) add(1, 0, 0, 0, 0, '0, '0, '0);
    repeat (8) add(1, 0, 0, 0, 0, '0, '0, '0);
    for (int ch = 0; ch < NCH; ch++) begin
      if (mask[ch]) begin
        int n;
        int idx;
        int mode;
        repeat (8) add(1, 0, 0, 0, 0, '0, '0, '0);
        n    = (m_cnt[ch] == 0) ? CMOD : m_cnt[ch];
        idx  = 0;
        mode = int'(m_ctrl[ch][4:2]);
        for (int b = 0; b < n; b++) begin
          logic [23:0] ma;
          logic [15:0] pa;
          logic [7:0]  d;
          ma = {m_bank[ch], m_off[ch]};
          pa = {8'h21, 8'(m_dest[ch] + 8'(pat_tab[mode][idx]))};
          if (!m_ctrl[ch][0]) begin
            d = mem_resp(ma);
            repeat (4) add(1, 1, 0, 0, 0, ma, pa, d);
            repeat (4) add(1, 0, 0, 0, 1, ma, pa, d);
          end else begin
            d = per_resp(pa);
            repeat (4) add(1, 0, 0, 1, 0, ma, pa, d);
            repeat (4) add(1, 0, 1, 0, 0, ma, pa, d);
          end
          if (!m_ctrl[ch][1]) m_off[ch] = m_off[ch] + 16'd1;
          m_cnt[ch] = (m_cnt[ch] + CMOD - 1) % CMOD;
          idx = (idx + 1) % pat_len[mode];
        end
      end
    end
    begin
      int w2;
      w2 = 8 - ((p + exp_q.size()) % 8);
      repeat (w2) add(1, 0, 0, 0, 0, '0, '0, '0);
    end
  endtask

  task automatic cmp(input rec_t e, input string lbl, input int i);
    chk(busy == e.busy, "R11", lbl, i, 32'(busy), 32'(e.busy));
    chk({mem_rd, mem_wr, per_rd, per_wr} == {e.mrd, e.mwr, e.prd, e.pwr}, "R5", lbl, i,
        32'({mem_rd, mem_wr, per_rd, per_wr}), 32'({e.mrd, e.mwr, e.prd, e.pwr}));
    chk(int'(cost) == e.cost, "R12", lbl, i, 32'(cost), 32'(e.cost));
    if (e.mrd || e.mwr) chk(mem_addr == e.ma, "R8", lbl, i, 32'(mem_addr), 32'(e.ma));
    if (e.prd || e.pwr) chk(per_addr == e.pa, "R6", lbl, i, 32'(per_addr), 32'(e.pa));
    if (e.mwr || e.pwr) chk(wdata == e.wd, "R7", lbl, i, 32'(wdata), 32'(e.wd));
  endtask

  task automatic run(input int p, input logic [NCH-1:0] mask, input int inj, input string lbl);
    int total;
    @(negedge clk);
    while ((cyc % 8) != p) @(negedge clk);
    start_we   = 1'b1;
    start_mask = mask;
    build(p, mask);
    total = exp_q.size();
    @(negedge clk);
    start_we = 1'b0;
    for (int i = 0; i < total; i++) begin
      if (i > 0) @(negedge clk);
      cmp(exp_q[i], lbl, i);
      if (i == inj) begin
        start_we   = 1'b1;
        start_mask = '1;
      end else begin
        start_we = 1'b0;
      end
    end
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      start_we = 1'b0;
      chk(busy == 1'b0, "R10", lbl, total + j, 32'(busy), 32'd0);
      chk({mem_rd, mem_wr, per_rd, per_wr} == 4'b0, "R5", lbl, total + j,
          32'({mem_rd, mem_wr, per_rd, per_wr}), 32'd0);
      chk(int'(cost) == total, "R12", lbl, total + j, 32'(cost), 32'(total));
    end
  endtask

  initial begin
    pat_len = '{1, 2, 2, 4, 4, 4, 2, 4};
    pat_tab = '{'{0, 0, 0, 0}, '{0, 1, 0, 0}, '{0, 0, 0, 0}, '{0, 0, 1, 1},
                '{0, 1, 2, 3}, '{0, 1, 0, 1}, '{0, 0, 0, 0}, '{0, 0, 1, 1}};
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk(busy == 1'b0, "R1", "reset", 0, 32'(busy), 32'd0);
    chk({mem_rd, mem_wr, per_rd, per_wr} == 4'b0, "R1", "reset", 0,
        32'({mem_rd, mem_wr, per_rd, per_wr}), 32'd0);
    chk(cost == '0, "R1", "reset", 0, 32'(cost), 32'd0);

    program_ch(0, 8'h00, 8'h18, 8'h7E, 16'h1000, 3);
    run(3, 8'h01, -1, "R2 R3 R9 R10 single channel");

    program_ch(1, 8'h10, 8'h40, 8'h01, 16'h2000, 5);
    program_ch(3, 8'h04, 8'hFF, 8'h03, 16'hFFFE, 3);
    program_ch(5, 8'h0F, 8'h80, 8'h02, 16'h3000, 2);
    program_ch(7, 8'h1D, 8'h10, 8'h04, 16'h0100, 4);
    run(0, 8'hAA, -1, "R2 R4 R6 R8 order aligned entry");

    program_ch(2, 8'h17, 8'h22, 8'h05, 16'h4000, 4);
    run(7, 8'h04, 10, "R11 R3 ignore start p7");

    program_ch(4, 8'h08, 8'h30, 8'h06, 16'h5000, 2);
    program_ch(6, 8'h19, 8'h60, 8'h07, 16'h6000, 3);
    run(5, 8'h50, -1, "R6 R7 modes 2 and 6");

    run(2, 8'h00, -1, "R4 R10 empty mask");

    run(1, 8'h01, -1, "R8 R9 count zero restart");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL R10 watchdog expired: actual busy=%0d expected run complete", busy);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule